// File: doc/BRIEF.md
# Power-Pulsed Clock Gating Controller

This block sits in the digital section of a multichannel front-end readout chip. It keeps the chip's internal clock and the bias of its differential receivers switched off except while a power-on window is open. A free-running source clock enters the block, and a gated copy leaves it. The gated copy carries whole pulses only during the digital power window. Two receiver-enable outputs follow the windows. The trigger-path enable, for the channel-reset/no-trigger and event-validation receivers, follows the analog power-on request, which covers the bunch-crossing period. The bias enable follows the digital power window.

The digital window has two sources, picked by a mode input. In acquisition/conversion mode the DAQ drives every chip together, and the window follows the digital power-on request. In readout mode the chips pass power along a daisy chain. The window opens on a start-of-readout marker and closes when the chip reports end of readout. A combinational wake output rises at once on any request that will open the digital window. It lets an upstream oscillator start asynchronously, while the gate itself is enabled and stopped synchronously.

All request and marker inputs pass through a synchronizer with a configurable number of stages. The gate enable is registered on the falling edge of the source clock.

Top module: `pp_clk_ctrl`

## Requirements
- R1: `gclk` is low whenever `clk` is low. It only turns on or off while `clk` is low, so every gated pulse is high for one full half period of `clk`.
- R2: `rx_trig_en` at each rising edge of `clk` equals `pwr_a_req` as sampled SYNC_STAGES+1 rising edges earlier (3 with the default of 2).
- R3: When `mode_readout` was 0 at the sampling edge, `rx_bias_en` takes the value that `pwr_d_req` had at the same sampling edge, with the same latency as R2.
- R4: When `mode_readout` was 1 at the sampling edge, `pwr_d_req` has no effect on the window. `start_readout` opens the window and `end_readout` closes it. If both are high at the same edge, the window closes. If neither is high, the window holds its state. Latency is the same as R2.
- R5: `gclk` gives exactly one pulse in each `clk` cycle whose rising edge follows an edge that left `rx_bias_en` high, and gives no pulse in any other cycle.
- R6: A synchronous active-high `rst` forces `rx_trig_en`, `rx_bias_en` and `gclk` to 0 and empties the synchronizers. Once all requests have been low for SYNC_STAGES+1 edges, every output except those that follow a still-open readout window is 0.
- R7: `wake` is combinational and equals `pwr_d_req | (mode_readout & start_readout) | rx_bias_en`, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running source clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_a_req | input | 1 | Analog power-on request (bunch-crossing window) |
| pwr_d_req | input | 1 | Digital power-on request, used in acquisition mode |
| mode_readout | input | 1 | 0 = acquisition/conversion, 1 = daisy-chained readout |
| start_readout | input | 1 | Readout start marker from the chain |
| end_readout | input | 1 | End-of-readout marker from this chip |
| gclk | output | 1 | Gated clock |
| wake | output | 1 | Asynchronous clock-start request |
| rx_trig_en | output | 1 | Enable for the reset/no-trigger and event-validation receivers |
| rx_bias_en | output | 1 | Receiver bias enable, high while the digital window is open |

## Verification
The hardest case to reach from the ports is a mode change that lands while a readout window is open or while start and end markers are in flight in the synchronizer. In that case the mode and the markers must be seen at the same sampling edge for the window to match. The stimulus mixes long random runs, with rare mode flips and independent single-cycle markers, with directed sequences. These sequences place start and end on the same edge, raise end without a prior start, and toggle the digital request during readout. A bench model delays every input by the synchronizer latency and predicts the gated pulse count for each cycle.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef struct packed {
    logic ana;
    logic dig;
    logic mode;
    logic start;
    logic stop;
  } pp_req_t;
  localparam int REQ_W = $bits(pp_req_t);
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pp_window.sv
module pp_window
  import pp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  pp_req_t req_s,
  output logic    win,
  output logic    trig_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      win     <= 1'b0;
      trig_en <= 1'b0;
    end else begin
      trig_en <= req_s.ana;
      if (!req_s.mode)     win <= req_s.dig;
      else if (req_s.stop) win <= 1'b0;
      else if (req_s.start) win <= 1'b1;
    end
  end
endmodule

// File: rtl/pp_clkgate.sv
module pp_clkgate (
  input  logic clk,
  input  logic rst,
  input  logic win,
  output logic gate_en,
  output logic gclk
);
  // Enable moves only on the falling edge, while clk is low.
  always_ff @(negedge clk) begin
    if (rst) gate_en <= 1'b0;
    else     gate_en <= win;
  end

  assign gclk = clk & gate_en;
endmodule

// File: rtl/pp_clk_ctrl.sv
module pp_clk_ctrl
  import pp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_a_req,
  input  logic pwr_d_req,
  input  logic mode_readout,
  input  logic start_readout,
  input  logic end_readout,
  output logic gclk,
  output logic wake,
  output logic rx_trig_en,
  output logic rx_bias_en
);
  pp_req_t req_raw, req_s;
  logic    win;
  logic    gate_en;

  always_comb begin
    req_raw.ana   = pwr_a_req;
    req_raw.dig   = pwr_d_req;
    req_raw.mode  = mode_readout;
    req_raw.start = start_readout;
    req_raw.stop  = end_readout;
  end

  pp_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_raw),
    .q   (req_s)
  );

  pp_window u_win (
    .clk     (clk),
    .rst     (rst),
    .req_s   (req_s),
    .win     (win),
    .trig_en (rx_trig_en)
  );

  pp_clkgate u_gate (
    .clk     (clk),
    .rst     (rst),
    .win     (win),
    .gate_en (gate_en),
    .gclk    (gclk)
  );

  assign rx_bias_en = win;
  assign wake = pwr_d_req | (mode_readout & start_readout) | win;
endmodule

// File: rtl/pp_clk_ctrl_chk.sv
module pp_clk_ctrl_chk #(
  parameter int STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic pwr_a_req,
  input logic pwr_d_req,
  input logic mode_readout,
  input logic start_readout,
  input logic end_readout,
  input logic gclk,
  input logic rx_trig_en,
  input logic rx_bias_en,
  input logic gate_en
);
  logic [STAGES:0] a_h, d_h, m_h, s_h, e_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_h <= '0; d_h <= '0; m_h <= '0; s_h <= '0; e_h <= '0;
    end else begin
      a_h <= {a_h[STAGES-1:0], pwr_a_req};
      d_h <= {d_h[STAGES-1:0], pwr_d_req};
      m_h <= {m_h[STAGES-1:0], mode_readout};
      s_h <= {s_h[STAGES-1:0], start_readout};
      e_h <= {e_h[STAGES-1:0], end_readout};
    end
  end

  a_r1_gclk_low_before_rise: assert property (@(posedge clk) disable iff (rst)
    !gclk);

  a_r2_trig_latency: assert property (@(posedge clk) disable iff (rst)
    rx_trig_en == a_h[STAGES]);

  a_r3_acq_follows_dig: assert property (@(posedge clk) disable iff (rst)
    !m_h[STAGES] |-> rx_bias_en == d_h[STAGES]);

  a_r4_end_closes: assert property (@(posedge clk) disable iff (rst)
    (m_h[STAGES] && e_h[STAGES]) |-> !rx_bias_en);

  a_r4_open_needs_start: assert property (@(posedge clk) disable iff (rst)
    (m_h[STAGES] && $rose(rx_bias_en)) |-> s_h[STAGES]);

  a_r5_gate_inside_window: assert property (@(posedge clk) disable iff (rst)
    gate_en |-> rx_bias_en);
endmodule

bind pp_clk_ctrl pp_clk_ctrl_chk #(.STAGES(SYNC_STAGES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .pwr_a_req     (pwr_a_req),
  .pwr_d_req     (pwr_d_req),
  .mode_readout  (mode_readout),
  .start_readout (start_readout),
  .end_readout   (end_readout),
  .gclk          (gclk),
  .rx_trig_en    (rx_trig_en),
  .rx_bias_en    (rx_bias_en),
  .gate_en       (gate_en)
);

// File: tb/pp_clk_ctrl_bench.sv
module pp_clk_ctrl_bench;
  localparam int STAGES = 2;
  localparam int DEPTH  = STAGES + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a = 0, d = 0, m = 0, s = 0, e = 0;
  logic gclk, wake, rx_trig_en, rx_bias_en;

  int checks = 0;
  int fails  = 0;
  int gcount = 0;
  int glast  = 0;
  realtime t_rise = 0.0;

  logic [4:0] q [DEPTH];
  logic exp_win  = 1'b0;
  logic exp_trig = 1'b0;

  pp_clk_ctrl #(.SYNC_STAGES(STAGES)) u_pp_clk_ctrl (
    .clk (clk), .rst (rst), .pwr_a_req (a), .pwr_d_req (d),
    .mode_readout (m), .start_readout (s), .end_readout (e),
    .gclk (gclk), .wake (wake), .rx_trig_en (rx_trig_en), .rx_bias_en (rx_bias_en)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp_v, $time);
    end
  endtask

  // R1: pulse width must be one half period of clk
  always @(posedge gclk) begin
    gcount++;
    t_rise = $realtime;
  end
  always @(negedge gclk) begin
    check(($realtime - t_rise) > 9.9, "R1 gated pulse width", int'($realtime - t_rise), 10);
  end

  function automatic logic next_win(input logic w, input logic [4:0] v);
    // v = {ana, dig, mode, start, stop}
    if (!v[2]) return v[3];
    if (v[0])  return 1'b0;
    if (v[1])  return 1'b1;
    return w;
  endfunction

  // one source cycle: drive at a falling edge, check at the next falling edge
  task automatic tick(input logic na, nd, nm, ns, ne, input logic nrst);
    logic pulse_exp;
    a = na; d = nd; m = nm; s = ns; e = ne; rst = nrst;
    #1;
    check(wake == (nd | (nm & ns) | exp_win), "R7 wake combinational", wake, nd | (nm & ns) | exp_win);
    @(negedge clk);
    #1;
    pulse_exp = exp_win;
    check((gcount - glast) == int'(pulse_exp), "R5 one pulse per open cycle", gcount - glast, pulse_exp);
    glast = gcount;
    for (int i = DEPTH - 1; i > 0; i--) q[i] = q[i-1];
    q[0] = nrst ? 5'b0 : {na, nd, nm, ns, ne};
    if (nrst) begin
      for (int i = 0; i < DEPTH; i++) q[i] = 5'b0;
      exp_win = 1'b0; exp_trig = 1'b0;
    end else begin
      exp_trig = q[DEPTH-1][4];
      exp_win  = next_win(exp_win, q[DEPTH-1]);
    end
    check(rx_trig_en == exp_trig, "R2 trigger receiver enable", rx_trig_en, exp_trig);
    check(rx_bias_en == exp_win, (q[DEPTH-1][2] ? "R4 readout window" : "R3 acquisition window"),
          rx_bias_en, exp_win);
    check(gclk == 1'b0, "R1 gclk low while clk low", gclk, 0);
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    logic ra, rd, rm;
    seed = $urandom(32'd2024);
    for (int i = 0; i < DEPTH; i++) q[i] = 5'b0;
    repeat (3) @(negedge clk);
    #1;
    // R6: reset state
    check(rx_trig_en == 0 && rx_bias_en == 0, "R6 reset outputs", rx_bias_en, 0);
    check(gcount == 0, "R6 no gated pulse in reset", gcount, 0);
    @(negedge clk);
    rst = 0;

    // R3: acquisition window, directed
    repeat (6) tick(0, 1, 0, 0, 0, 0);
    check(rx_bias_en == 1, "R3 window open after request", rx_bias_en, 1);
    repeat (4) tick(1, 0, 0, 0, 0, 0);
    check(rx_trig_en == 1 && rx_bias_en == 0, "R2 analog only", rx_trig_en, 1);

    // R4: readout mode, digital request ignored
    repeat (4) tick(0, 0, 1, 0, 0, 0);
    tick(0, 0, 1, 1, 0, 0);
    repeat (4) tick(0, 1, 1, 0, 0, 0);
    tick(0, 0, 1, 0, 0, 0);
    check(rx_bias_en == 1, "R4 start opens window", rx_bias_en, 1);
    repeat (4) tick(0, 0, 1, 0, 0, 0);
    check(rx_bias_en == 1, "R4 dig request ignored", rx_bias_en, 1);
    tick(0, 0, 1, 1, 1, 0);
    repeat (3) tick(0, 0, 1, 0, 0, 0);
    check(rx_bias_en == 0, "R4 end wins over start", rx_bias_en, 0);
    tick(0, 0, 1, 0, 1, 0);
    repeat (3) tick(0, 0, 1, 0, 0, 0);
    check(rx_bias_en == 0, "R4 end without start", rx_bias_en, 0);

    // R6: reset in the middle of an open window
    tick(0, 0, 1, 1, 0, 0);
    repeat (4) tick(1, 0, 1, 0, 0, 0);
    tick(1, 0, 1, 0, 0, 1);
    check(rx_bias_en == 0 && rx_trig_en == 0, "R6 reset closes window", rx_bias_en, 0);
    repeat (2) tick(0, 0, 0, 0, 0, 0);

    // random phase
    ra = 0; rd = 0; rm = 0;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0)   ra = ~ra;
      if ($urandom_range(7) == 0)   rd = ~rd;
      if ($urandom_range(150) == 0) rm = ~rm;
      tick(ra, rd, rm, $urandom_range(9) == 0, $urandom_range(9) == 0, 0);
    end

    // R6: all requests low leads to everything off
    repeat (3) tick(0, 0, 0, 0, 0, 0);
    glast = gcount;
    repeat (5) tick(0, 0, 0, 0, 0, 0);
    check(rx_bias_en == 0 && rx_trig_en == 0, "R6 all off when idle", rx_bias_en, 0);
    check(gcount == glast, "R6 no gated pulse when idle", gcount - glast, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule